// File: doc/BRIEF.md
# Byte-Accessed Modulo Timer Counter

This block is a 16-bit timer counter with a programmable end value (the modulo). A narrow 8-bit register bus reaches both values as separate high and low bytes. The counter moves one step on each bus-clock cycle where an external prescaler raises a count-enable strobe. In edge-aligned mode it counts up and wraps to zero after it reaches the modulo. In center-aligned mode it counts up to the modulo, turns around, and counts back down to zero.

Each end of a count period sets an overflow flag. The flag can drive an interrupt output. Three mechanisms keep byte accesses coherent. The low counter byte is held when the high byte is read. A new modulo takes effect only once both of its bytes are present. Overflow reporting is withheld while a modulo update is half-written. A debug halt input freezes the counter and the read-hold state.

Top module: `modtmr_top`

Register addresses: 0 control/status, 1 counter high byte, 2 counter low byte, 3 modulo high byte, 4 modulo low byte. Unused addresses read as zero. The control/status byte has three fields: bit 7 is the overflow flag, bit 6 is the interrupt enable, and bit 5 is the mode (0 edge-aligned, 1 center-aligned).

## Requirements
- R1: After reset the counter, the active modulo, the control/status byte and irq are all zero, and every register address reads 0x00.
- R2: The counter moves by exactly one count per cycle in which cnt_en is 1 and halt is 0, and holds in every other cycle.
- R3: A write to address 1 or address 2 sets the whole counter to zero whatever the data, and makes the next count go upward.
- R4: In edge-aligned mode (bit 5 = 0) with a nonzero modulo M, an enabled step from M gives 0 and sets the flag (bit 7).
- R5: With a modulo of zero the counter runs through 0xFFFF, and the enabled step from 0xFFFF gives 0 and sets the flag.
- R6: In center-aligned mode (bit 5 = 1) the counter reverses at M and falls by one per enabled step. The enabled step from 0 while falling goes to 1, sets the flag, and resumes counting upward.
- R7: Bytes written to addresses 3 and 4 are held aside. The active modulo, which addresses 3 and 4 read back, changes only when both bytes have been written, in either order, and then changes to both at once.
- R8: While exactly one modulo byte is held aside, a wrap or turnaround does not set the flag and does not raise irq.
- R9: Reading address 1 captures the low counter byte. The next read of address 2 returns the captured byte. After that read, or after a counter write, address 2 returns the live low byte again.
- R10: While halt is 1 the counter does not move and a read of address 1 does not capture the low byte.
- R11: The flag clears only when the control/status byte is written with bit 7 = 0 after a read of that byte that saw the flag set. A write with no such read before it leaves the flag set. If a flag-setting event and a clear arrive in the same cycle, the flag stays set.
- R12: irq equals the flag ANDed with the interrupt enable (bit 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt | input | 1 | Debug halt: freezes counter and read-hold state |
| cnt_en | input | 1 | Count-enable strobe from the prescaler |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | Overflow interrupt |

## Verification
Read data depends only on the current address and the present state, so it is due in the same cycle as the read strobe. The bench samples it one time unit after the falling edge that applies the strobe. Writes, count steps and their side effects take hold at the next rising edge. They become visible at the following falling edge, and irq follows the flag with no extra delay. A behavioural model in the bench steps at each rising edge and is compared against bus_rdata and irq at every falling edge. Directed reads with hand-computed values cover the wrap, turnaround, hold and suppression corners.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int REG_CTRL = 0;
   localparam int REG_CNTH = 1;
   localparam int REG_CNTL = 2;
   localparam int REG_MODH = 3;
   localparam int REG_MODL = 4;

   localparam int FLAG_BIT = 7;
   localparam int IE_BIT   = 6;
   localparam int MODE_BIT = 5;
endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int  CNT_W     = 16,
   parameter bit  CENTER_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic             center,
   input  logic [CNT_W-1:0] mod_val,
   output logic [CNT_W-1:0] count,
   output logic             wrap_evt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             center_eff;
   logic             dn;
   logic             dn_nxt;
   logic [CNT_W-1:0] top;
   logic [CNT_W-1:0] cnt_nxt;

   generate
      if (CENTER_EN) begin : g_center
         assign center_eff = center;
      end else begin : g_edge_only
         assign center_eff = 1'b0;
      end
   endgenerate

   assign top = (mod_val == '0) ? '1 : mod_val;

   always_comb begin
      cnt_nxt  = count;
      dn_nxt   = dn;
      wrap_evt = 1'b0;
      if (clr) begin
         cnt_nxt = '0;
         dn_nxt  = 1'b0;
      end else if (step) begin
         if (!center_eff) begin
            dn_nxt = 1'b0;
            if (count == top) begin
               cnt_nxt  = '0;
               wrap_evt = 1'b1;
            end else begin
               cnt_nxt = count + ONE;
            end
         end else if (!dn) begin
            if (count >= top) begin
               dn_nxt  = 1'b1;
               cnt_nxt = count - ONE;
            end else begin
               cnt_nxt = count + ONE;
            end
         end else begin
            if (count == '0) begin
               dn_nxt   = 1'b0;
               cnt_nxt  = ONE;
               wrap_evt = 1'b1;
            end else begin
               cnt_nxt = count - ONE;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         dn    <= 1'b0;
      end else begin
         count <= cnt_nxt;
         dn    <= dn_nxt;
      end
   end

   AST_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0)); // R3
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && !dn && (count < top)) |=> (count == $past(count) + ONE)); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr) |=> $stable(count)); // R10
   AST_EDGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && !center_eff && (count == top)) |=> (count == '0)); // R4
endmodule

// File: rtl/tmr_mod_stage.sv
module tmr_mod_stage #(
   parameter int BUS_W = 8,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hi,
   input  logic             wr_lo,
   input  logic [BUS_W-1:0] wdata,
   output logic [CNT_W-1:0] mod_val,
   output logic             busy
);
   localparam int HI_W = CNT_W - BUS_W;

   logic             got_hi;
   logic             got_lo;
   logic [HI_W-1:0]  hold_hi;
   logic [BUS_W-1:0] hold_lo;

   assign busy = got_hi | got_lo;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         got_hi  <= 1'b0;
         got_lo  <= 1'b0;
         hold_hi <= '0;
         hold_lo <= '0;
         mod_val <= '0;
      end else if (wr_hi) begin
         if (got_lo) begin
            mod_val <= {wdata[HI_W-1:0], hold_lo};
            got_lo  <= 1'b0;
            got_hi  <= 1'b0;
         end else begin
            hold_hi <= wdata[HI_W-1:0];
            got_hi  <= 1'b1;
         end
      end else if (wr_lo) begin
         if (got_hi) begin
            mod_val <= {hold_hi, wdata};
            got_hi  <= 1'b0;
            got_lo  <= 1'b0;
         end else begin
            hold_lo <= wdata;
            got_lo  <= 1'b1;
         end
      end
   end

   AST_MOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hi && !wr_lo) |=> $stable(mod_val)); // R7
   AST_MOD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy) |=> $stable(mod_val)); // R7
endmodule

// File: rtl/tmr_rd_hold.sv
module tmr_rd_hold #(
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt,
   input  logic             rd_hi,
   input  logic             rd_lo,
   input  logic             cnt_wr,
   input  logic [BUS_W-1:0] live_lo,
   output logic [BUS_W-1:0] lo_out
);
   logic             held;
   logic [BUS_W-1:0] hold_q;

   assign lo_out = held ? hold_q : live_lo;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held   <= 1'b0;
         hold_q <= '0;
      end else if (cnt_wr) begin
         held <= 1'b0;
      end else if (!halt) begin
         if (rd_hi) begin
            held   <= 1'b1;
            hold_q <= live_lo;
         end else if (rd_lo) begin
            held <= 1'b0;
         end
      end
   end

   AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !cnt_wr) |=> ($stable(held) && $stable(hold_q))); // R10
   AST_LATCH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr || (rd_lo && !rd_hi && !halt)) |=> !held); // R9
endmodule

// File: rtl/modtmr_top.sv
module modtmr_top
   import tmr_pkg::*;
#(
   parameter int BUS_W     = 8,
   parameter int CNT_W     = 16,
   parameter int ADDR_W    = 3,
   parameter bit CENTER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halt,
   input  logic              cnt_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq
);
   generate
      if (CNT_W != 2 * BUS_W) begin : g_bad_width
         $error("counter width must be twice the bus width");
      end
      if (BUS_W < 8) begin : g_bad_bus
         $error("bus must be at least 8 bits for the control byte");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("address must be at least 3 bits");
      end
   endgenerate

   logic wr_ctrl, wr_cnth, wr_cntl, wr_modh, wr_modl;
   logic rd_ctrl, rd_cnth, rd_cntl;
   logic cnt_wr, step;
   logic ie_q, mode_q, flag_q, arm_q;
   logic wrap_evt, mod_busy;
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] mod_val;
   logic [BUS_W-1:0] lo_rd;

   assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
   assign wr_cnth = bus_wr && (bus_addr == ADDR_W'(REG_CNTH));
   assign wr_cntl = bus_wr && (bus_addr == ADDR_W'(REG_CNTL));
   assign wr_modh = bus_wr && (bus_addr == ADDR_W'(REG_MODH));
   assign wr_modl = bus_wr && (bus_addr == ADDR_W'(REG_MODL));
   assign rd_ctrl = bus_rd && (bus_addr == ADDR_W'(REG_CTRL));
   assign rd_cnth = bus_rd && (bus_addr == ADDR_W'(REG_CNTH));
   assign rd_cntl = bus_rd && (bus_addr == ADDR_W'(REG_CNTL));
   assign cnt_wr  = wr_cnth | wr_cntl;
   assign step    = cnt_en & ~halt;

   tmr_count_core #(.CNT_W(CNT_W), .CENTER_EN(CENTER_EN)) u_core (
      .clk(clk), .rst_n(rst_n), .clr(cnt_wr), .step(step), .center(mode_q),
      .mod_val(mod_val), .count(count), .wrap_evt(wrap_evt)
   );

   tmr_mod_stage #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_mod (
      .clk(clk), .rst_n(rst_n), .wr_hi(wr_modh), .wr_lo(wr_modl),
      .wdata(bus_wdata), .mod_val(mod_val), .busy(mod_busy)
   );

   tmr_rd_hold #(.BUS_W(BUS_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .halt(halt), .rd_hi(rd_cnth), .rd_lo(rd_cntl),
      .cnt_wr(cnt_wr), .live_lo(count[BUS_W-1:0]), .lo_out(lo_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q   <= 1'b0;
         mode_q <= 1'b0;
         flag_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ie_q   <= bus_wdata[IE_BIT];
            mode_q <= bus_wdata[MODE_BIT];
            arm_q  <= 1'b0;
         end else if (rd_ctrl && flag_q) begin
            arm_q <= 1'b1;
         end
         if (wrap_evt && !mod_busy) begin
            flag_q <= 1'b1;
         end else if (wr_ctrl && arm_q && !bus_wdata[FLAG_BIT]) begin
            flag_q <= 1'b0;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(REG_CTRL)) begin
         bus_rdata[FLAG_BIT] = flag_q;
         bus_rdata[IE_BIT]   = ie_q;
         bus_rdata[MODE_BIT] = mode_q;
      end else if (bus_addr == ADDR_W'(REG_CNTH)) begin
         bus_rdata = count[CNT_W-1:BUS_W];
      end else if (bus_addr == ADDR_W'(REG_CNTL)) begin
         bus_rdata = lo_rd;
      end else if (bus_addr == ADDR_W'(REG_MODH)) begin
         bus_rdata = mod_val[CNT_W-1:BUS_W];
      end else if (bus_addr == ADDR_W'(REG_MODL)) begin
         bus_rdata = mod_val[BUS_W-1:0];
      end
   end

   assign irq = flag_q & ie_q;

   AST_NO_FLAG_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_busy && !flag_q) |=> !flag_q); // R8
   AST_FLAG_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !wr_ctrl) |=> flag_q); // R11
   AST_FLAG_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !arm_q) |=> flag_q); // R11
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie_q && !wr_ctrl) |=> !irq); // R12
endmodule

// File: tb/modtmr_top_test.sv
module modtmr_top_test;
   localparam int CLK_PER = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       halt = 1'b0;
   logic       cnt_en = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq;

   int checks = 0;
   int errors = 0;

   modtmr_top uut (
      .clk(clk), .rst_n(rst_n), .halt(halt), .cnt_en(cnt_en),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   always #(CLK_PER/2) clk = ~clk;

   // behavioural reference state
   int  m_cnt, m_mod, m_bh, m_bl, m_lbuf;
   bit  m_dn, m_flag, m_arm, m_ie, m_ctr, m_hb, m_lb, m_lat;

   function automatic int m_read(input int a);
      case (a)
         0: return (m_flag ? 128 : 0) + (m_ie ? 64 : 0) + (m_ctr ? 32 : 0);
         1: return (m_cnt >> 8) & 255;
         2: return m_lat ? m_lbuf : (m_cnt & 255);
         3: return (m_mod >> 8) & 255;
         4: return m_mod & 255;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      int top, nc;
      bit ev, busy_old;
      if (!rst_n) begin
         m_cnt = 0; m_mod = 0; m_bh = 0; m_bl = 0; m_lbuf = 0;
         m_dn = 0; m_flag = 0; m_arm = 0; m_ie = 0; m_ctr = 0;
         m_hb = 0; m_lb = 0; m_lat = 0;
      end else begin
         top = (m_mod == 0) ? 65535 : m_mod;
         ev = 0;
         nc = m_cnt;
         busy_old = m_hb || m_lb;
         if (bus_wr && (bus_addr == 1 || bus_addr == 2)) begin
            nc = 0; m_dn = 0; m_lat = 0;
         end else begin
            if (cnt_en && !halt) begin
               if (!m_ctr) begin
                  if (m_cnt == top) begin nc = 0; ev = 1; end
                  else nc = (m_cnt + 1) % 65536;
               end else if (!m_dn) begin
                  if (m_cnt >= top) begin m_dn = 1; nc = m_cnt - 1; end
                  else nc = m_cnt + 1;
               end else begin
                  if (m_cnt == 0) begin m_dn = 0; nc = 1; ev = 1; end
                  else nc = m_cnt - 1;
               end
            end
            if (!halt && bus_rd && bus_addr == 1) begin
               m_lat = 1; m_lbuf = m_cnt & 255;
            end else if (!halt && bus_rd && bus_addr == 2) begin
               m_lat = 0;
            end
         end
         if (bus_wr && bus_addr == 0 && m_arm && !bus_wdata[7]) m_flag = 0;
         if (ev && !busy_old) m_flag = 1;
         if (bus_wr && bus_addr == 0) begin
            m_arm = 0; m_ie = bus_wdata[6]; m_ctr = bus_wdata[5];
         end else if (bus_rd && bus_addr == 0 && m_read(0) >= 128) begin
            m_arm = 1;
         end
         if (bus_wr && bus_addr == 3) begin
            if (m_lb) begin m_mod = bus_wdata * 256 + m_bl; m_hb = 0; m_lb = 0; end
            else begin m_bh = bus_wdata; m_hb = 1; end
         end else if (bus_wr && bus_addr == 4) begin
            if (m_hb) begin m_mod = m_bh * 256 + bus_wdata; m_hb = 0; m_lb = 0; end
            else begin m_bl = bus_wdata; m_lb = 1; end
         end
         m_cnt = nc;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference model
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         string tg;
         case (bus_addr)
            3'd0: tg = "R11 model ctrl";
            3'd1: tg = "R2 model cnt_hi";
            3'd2: tg = "R9 model cnt_lo";
            default: tg = "R7 model other";
         endcase
         chk(int'(bus_rdata) == m_read(int'(bus_addr)), tg, int'(bus_rdata), m_read(int'(bus_addr)));
         chk(irq == (m_flag && m_ie), "R12 model irq", int'(irq), int'(m_flag && m_ie));
      end
   end

   task automatic bus_write(input int a, input int d);
      @(negedge clk);
      bus_addr = a[2:0]; bus_wdata = d[7:0]; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input int a, input int exp, input string tag);
      @(negedge clk);
      bus_addr = a[2:0]; bus_rd = 1'b1;
      #2;
      chk(int'(bus_rdata) == exp, tag, int'(bus_rdata), exp);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic steps(input int n);
      @(negedge clk);
      cnt_en = 1'b1;
      repeat (n) @(negedge clk);
      cnt_en = 1'b0;
   endtask

   task automatic irq_is(input bit exp, input string tag);
      @(negedge clk);
      #2;
      chk(irq == exp, tag, int'(irq), int'(exp));
   endtask

   task automatic finish_run;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual running expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      for (int a = 0; a < 6; a++) bus_read(a, 0, "R1 reset read");
      irq_is(1'b0, "R1 reset irq");

      // R2: counting with free-run modulo
      steps(10);
      bus_read(1, 0, "R2 count hi");
      bus_read(2, 10, "R2 count lo (held)");
      bus_read(2, 10, "R2 count lo live");

      // R9: high read holds low byte
      bus_read(1, 0, "R9 hi read");
      steps(3);
      bus_read(2, 10, "R9 held low");
      bus_read(2, 13, "R9 released low");
      bus_read(1, 0, "R9 hi read again");
      bus_write(2, 8'h5A);
      bus_read(2, 0, "R3 clear via low write, R9 release");
      steps(4);
      bus_write(1, 8'hFF);
      bus_read(2, 0, "R3 clear via high write");

      // R10: halt freezes counter and hold state
      steps(5);
      @(negedge clk); halt = 1'b1;
      bus_read(1, 0, "R10 hi read in halt");
      steps(4);
      bus_read(2, 5, "R10 frozen count");
      @(negedge clk); halt = 1'b0;
      steps(2);
      bus_read(2, 7, "R10 no hold from halted read");

      // R7: modulo staging
      bus_write(3, 0);
      bus_read(4, 0, "R7 modulo unchanged after one byte");
      bus_write(4, 5);
      bus_read(4, 5, "R7 modulo lo committed");
      bus_read(3, 0, "R7 modulo hi committed");

      // R4: edge wrap at modulo 5
      bus_write(2, 0);
      steps(5);
      bus_read(2, 5, "R4 at modulo");
      bus_read(0, 8'h00, "R4 no flag yet");
      steps(1);
      bus_read(2, 0, "R4 wrapped to zero");
      bus_read(0, 8'h80, "R4 flag set");
      irq_is(1'b0, "R12 irq off with enable clear");

      // R11: clear needs a prior read that saw the flag
      bus_write(0, 8'hC0);
      bus_write(0, 8'h40);
      irq_is(1'b1, "R12 irq with enable set");
      bus_read(0, 8'hC0, "R11 flag survives write without read");
      bus_write(0, 8'h40);
      irq_is(1'b0, "R12 irq drops with flag");
      bus_read(0, 8'h40, "R11 flag cleared");

      // R8: half-written modulo suppresses the flag
      bus_write(3, 0);
      bus_write(2, 0);
      steps(8);
      bus_read(0, 8'h40, "R8 flag suppressed");
      irq_is(1'b0, "R8 irq suppressed");
      bus_read(2, 2, "R8 counter still wrapped at old modulo");
      bus_write(4, 3);
      bus_read(4, 3, "R7 hi-then-lo commit");

      // R6: center-aligned up/down with modulo 3
      bus_write(0, 8'h20);
      bus_write(2, 0);
      steps(1); bus_read(2, 1, "R6 up 1");
      steps(1); bus_read(2, 2, "R6 up 2");
      steps(1); bus_read(2, 3, "R6 top");
      steps(1); bus_read(2, 2, "R6 down 2");
      steps(1); bus_read(2, 1, "R6 down 1");
      steps(1); bus_read(2, 0, "R6 bottom");
      bus_read(0, 8'h20, "R6 no flag before turnaround");
      steps(1); bus_read(2, 1, "R6 turnaround up");
      bus_read(0, 8'hA0, "R6 flag at turnaround");

      // R5: modulo zero free-runs the full range
      bus_write(0, 8'h00);
      bus_read(0, 8'h00, "R11 armed clear");
      bus_write(4, 0);
      bus_write(3, 0);
      bus_read(4, 0, "R7 lo-then-hi commit");
      bus_write(2, 0);
      steps(65535);
      bus_read(1, 8'hFF, "R5 hi at max");
      bus_read(2, 8'hFF, "R5 lo at max");
      bus_read(0, 8'h00, "R5 no flag at max");
      steps(1);
      bus_read(2, 0, "R5 rolled to zero");
      bus_read(0, 8'h80, "R5 flag after full range");

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule